// File: doc/BRIEF.md
# Serial Byte-Command Debug Stepper

This controller sits between a byte-wide serial receiver and transmitter pair and a user design whose every register is gated by a clock-enable. The gated design stays frozen while the enable is low. A host moves it forward by sending a null byte. Each null byte opens a burst of a fixed, parameter-chosen number of enabled clocks. With a count of one, this is plain single-stepping.

The controller treats every received byte, null or not, as a read address into a bank of 8-bit probe inputs. It sends the selected byte back on the following clock. Address zero and any address beyond the probe bank return zero. Because all 256 byte values are meaningful, the host tool must be able to send raw binary bytes, not just printable ones.

A one-entry reply slot holds the answer while the transmitter reports busy, so no reply is lost. A request that arrives while that slot is still blocked is discarded, and a sticky flag records the loss.

Top module: `dbg_step_ctrl`

## Requirements
- R1: A synchronous active-high reset drives step_en, tx_valid and overrun low, and clears the burst counter.
- R2: A received byte of 8'h00 (rx_valid high) makes step_en high for exactly NCLOCKS consecutive clocks, starting the clock after the strobe. step_en is low at all other times.
- R3: A received byte other than 8'h00 never raises step_en.
- R4: An 8'h00 received while a burst is running restarts the count, so step_en stays high for NCLOCKS clocks after that later strobe.
- R5: A received byte that is accepted raises tx_valid on the next clock, carrying the reply byte.
- R6: For 1 <= a <= PROBES, address a returns probe_bus[8a-1 : 8a-8]. This means probe k (0-based) answers address k+1.
- R7: Address 8'h00, and any address above PROBES, return 8'h00.
- R8: While tx_valid and tx_busy are both high, tx_valid stays high and tx_byte stays unchanged. After a clock with tx_valid high and tx_busy low, tx_valid falls unless a new request was loaded in that clock.
- R9: A request that arrives while tx_valid and tx_busy are both high is dropped. The pending reply is kept, and overrun goes high and stays high until reset.
- R10: A request that arrives in the same clock as the acceptance of the pending reply (tx_busy low) is loaded, and its reply appears on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-clock strobe for each received byte |
| rx_byte | input | 8 | Received byte, valid while rx_valid is high |
| tx_busy | input | 1 | Transmitter cannot take a byte this clock |
| probe_bus | input | 8*PROBES | Probe values, with probe k in bits [8k+7:8k] |
| tx_valid | output | 1 | Reply byte offered to the transmitter |
| tx_byte | output | 8 | Reply byte |
| step_en | output | 1 | Clock-enable for the gated design |
| overrun | output | 1 | Sticky flag: a request was dropped |

## Verification
The bench builds the block with PROBES = 6 and NCLOCKS = 3. Six probes leave addresses 7 through 255 unmapped, so the zero return for unmapped addresses can be tested next to mapped ones. A three-clock burst is long enough to send a second null byte in the middle of a burst and measure the extended run, and to show that non-null bytes in between do not touch the enable. The transmitter busy input is held high across several requests to exercise holding the reply, dropping a request, and the case where a request is loaded in the same clock the pending reply is accepted.

// File: rtl/dbg_step_pkg.sv
package dbg_step_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;
   localparam byte_t STEP_CMD  = 8'h00;
   localparam byte_t ZERO_BYTE = 8'h00;
endpackage

// File: rtl/dbg_step_burst.sv
module dbg_step_burst
   import dbg_step_pkg::*;
#(
   parameter int NCLOCKS = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic go,
   output logic step_en
);
   generate
      if (NCLOCKS == 1) begin : g_single
         // single-step: enable is just the delayed command strobe
         always_ff @(posedge clk) begin
            if (rst) step_en <= 1'b0;
            else     step_en <= go;
         end
      end else begin : g_burst
         localparam int CW = $clog2(NCLOCKS);
         localparam logic [CW-1:0] RELOAD = CW'(NCLOCKS - 1);
         logic [CW-1:0] left_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               left_q  <= '0;
               step_en <= 1'b0;
            end else if (go) begin
               left_q  <= RELOAD;
               step_en <= 1'b1;
            end else if (left_q != '0) begin
               left_q  <= left_q - 1'b1;
               step_en <= 1'b1;
            end else begin
               step_en <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dbg_probe_mux.sv
module dbg_probe_mux
   import dbg_step_pkg::*;
#(
   parameter int PROBES = 6
) (
   input  byte_t                     addr,
   input  logic [PROBES*BYTE_W-1:0]  probe_bus,
   output byte_t                     data
);
   logic [PROBES-1:0] hit;
   byte_t             pick [PROBES];

   generate
      for (genvar k = 0; k < PROBES; k++) begin : g_lane
         assign hit[k]  = (addr == byte_t'(k + 1));
         assign pick[k] = hit[k] ? probe_bus[k*BYTE_W +: BYTE_W] : ZERO_BYTE;
      end
   endgenerate

   always_comb begin
      data = ZERO_BYTE;
      for (int k = 0; k < PROBES; k++) data = data | pick[k];
   end
endmodule

// File: rtl/dbg_reply_slot.sv
module dbg_reply_slot
   import dbg_step_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  req,
   input  byte_t req_data,
   input  logic  tx_busy,
   output logic  tx_valid,
   output byte_t tx_byte,
   output logic  overrun
);
   logic blocked;
   logic load;

   assign blocked = tx_valid & tx_busy;
   assign load    = req & ~blocked;

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_valid <= 1'b0;
         tx_byte  <= ZERO_BYTE;
         overrun  <= 1'b0;
      end else begin
         if (load) begin
            tx_valid <= 1'b1;
            tx_byte  <= req_data;
         end else if (tx_valid && !tx_busy) begin
            tx_valid <= 1'b0;
         end
         if (req && blocked) overrun <= 1'b1;
      end
   end
endmodule

// File: rtl/dbg_step_ctrl.sv
module dbg_step_ctrl
   import dbg_step_pkg::*;
#(
   parameter int PROBES  = 6,
   parameter int NCLOCKS = 3
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     rx_valid,
   input  logic [7:0]               rx_byte,
   input  logic                     tx_busy,
   input  logic [PROBES*8-1:0]      probe_bus,
   output logic                     tx_valid,
   output logic [7:0]               tx_byte,
   output logic                     step_en,
   output logic                     overrun
);
   generate
      if (PROBES < 4 || PROBES > 255) begin : g_bad_probes
         $error("dbg_step_ctrl: PROBES must lie in 4..255");
      end
      if (NCLOCKS < 1) begin : g_bad_clocks
         $error("dbg_step_ctrl: NCLOCKS must be at least 1");
      end
   endgenerate

   logic  go_step;
   byte_t lookup;

   assign go_step = rx_valid && (rx_byte == STEP_CMD);

   dbg_step_burst #(.NCLOCKS(NCLOCKS)) u_burst (
      .clk     (clk),
      .rst     (rst),
      .go      (go_step),
      .step_en (step_en)
   );

   dbg_probe_mux #(.PROBES(PROBES)) u_mux (
      .addr      (rx_byte),
      .probe_bus (probe_bus),
      .data      (lookup)
   );

   dbg_reply_slot u_slot (
      .clk      (clk),
      .rst      (rst),
      .req      (rx_valid),
      .req_data (lookup),
      .tx_busy  (tx_busy),
      .tx_valid (tx_valid),
      .tx_byte  (tx_byte),
      .overrun  (overrun)
   );
endmodule

// File: rtl/dbg_step_ctrl_chk.sv
module dbg_step_ctrl_chk #(
   parameter int PROBES  = 6,
   parameter int NCLOCKS = 3
) (
   input logic       clk,
   input logic       rst,
   input logic       rx_valid,
   input logic [7:0] rx_byte,
   input logic       tx_busy,
   input logic       tx_valid,
   input logic [7:0] tx_byte,
   input logic       step_en,
   input logic       overrun
);
   localparam int MW = $clog2(NCLOCKS + 1);
   logic [MW-1:0] model_left;

   // independent window counter for the burst length
   always_ff @(posedge clk) begin
      if (rst)                               model_left <= '0;
      else if (rx_valid && rx_byte == 8'h00) model_left <= MW'(NCLOCKS);
      else if (model_left != '0)             model_left <= model_left - 1'b1;
   end

   p_burst_len_r2: assert property (@(posedge clk) disable iff (rst)
      step_en == (model_left != '0));

   p_null_starts_r4: assert property (@(posedge clk) disable iff (rst)
      rx_valid && rx_byte == 8'h00 |=> step_en);

   p_reply_next_r5: assert property (@(posedge clk) disable iff (rst)
      rx_valid && !(tx_valid && tx_busy) |=> tx_valid);

   p_zero_addr_r7: assert property (@(posedge clk) disable iff (rst)
      rx_valid && rx_byte == 8'h00 && !(tx_valid && tx_busy) |=> tx_byte == 8'h00);

   p_hold_busy_r8: assert property (@(posedge clk) disable iff (rst)
      tx_valid && tx_busy |=> tx_valid && $stable(tx_byte));

   p_drop_flag_r9: assert property (@(posedge clk) disable iff (rst)
      rx_valid && tx_valid && tx_busy |=> overrun);

   p_no_overflow_clear_r9: assert property (@(posedge clk) disable iff (rst)
      overrun |=> overrun);
endmodule

bind dbg_step_ctrl dbg_step_ctrl_chk #(.PROBES(PROBES), .NCLOCKS(NCLOCKS)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .rx_valid (rx_valid),
   .rx_byte  (rx_byte),
   .tx_busy  (tx_busy),
   .tx_valid (tx_valid),
   .tx_byte  (tx_byte),
   .step_en  (step_en),
   .overrun  (overrun)
);

// File: tb/dbg_step_ctrl_bench.sv
module dbg_step_ctrl_bench;
   localparam int PROBES  = 6;
   localparam int NCLOCKS = 3;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 rx_valid = 1'b0;
   logic [7:0]           rx_byte = 8'h00;
   logic                 tx_busy = 1'b0;
   logic [PROBES*8-1:0]  probe_bus;
   logic                 tx_valid;
   logic [7:0]           tx_byte;
   logic                 step_en;
   logic                 overrun;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   dbg_step_ctrl #(.PROBES(PROBES), .NCLOCKS(NCLOCKS)) u_dbg_step_ctrl (
      .clk (clk), .rst (rst), .rx_valid (rx_valid), .rx_byte (rx_byte),
      .tx_busy (tx_busy), .probe_bus (probe_bus), .tx_valid (tx_valid),
      .tx_byte (tx_byte), .step_en (step_en), .overrun (overrun)
   );

   // probe k carries {4'hA, k}
   always_comb
      for (int k = 0; k < PROBES; k++) probe_bus[k*8 +: 8] = {4'hA, 4'(k)};

   function automatic logic [7:0] expect_reply(input logic [7:0] a);
      if (a >= 8'd1 && a <= 8'(PROBES)) return {4'hA, 4'(a - 8'd1)};
      return 8'h00;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // caller sits at a negedge; returns at the next negedge
   task automatic send(input logic [7:0] b);
      rx_valid = 1'b1;
      rx_byte  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      tx_busy = 1'b0;
      do_reset();
      chk("R1 step_en", step_en, 0);
      chk("R1 tx_valid", tx_valid, 0);
      chk("R1 overrun", overrun, 0);
   endtask

   task automatic t_single_burst();
      send(8'h00);
      chk("R5 reply valid", tx_valid, 1);
      chk("R7 null reply", tx_byte, 8'h00);
      for (int i = 0; i < NCLOCKS + 2; i++) begin
         chk("R2 burst", step_en, (i < NCLOCKS) ? 1 : 0);
         @(negedge clk);
      end
   endtask

   task automatic t_non_null();
      logic [7:0] codes [4] = '{8'h01, 8'h30, 8'h80, 8'hFF};
      foreach (codes[i]) begin
         send(codes[i]);
         chk("R3 no step", step_en, 0);
         @(negedge clk);
         chk("R3 no step later", step_en, 0);
      end
   endtask

   task automatic t_restart();
      send(8'h00);
      send(8'h00);
      for (int i = 0; i < NCLOCKS + 2; i++) begin
         chk("R4 restart", step_en, (i < NCLOCKS) ? 1 : 0);
         @(negedge clk);
      end
   endtask

   task automatic t_addresses();
      logic [7:0] addrs [8] = '{8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'hFF};
      foreach (addrs[i]) begin
         send(addrs[i]);
         chk("R5 reply valid", tx_valid, 1);
         if (addrs[i] <= 8'(PROBES)) chk("R6 probe read", tx_byte, expect_reply(addrs[i]));
         else                        chk("R7 unmapped read", tx_byte, 8'h00);
         @(negedge clk);
         chk("R8 reply taken", tx_valid, 0);
      end
   endtask

   task automatic t_busy();
      tx_busy = 1'b1;
      send(8'd2);
      chk("R5 busy reply", tx_valid, 1);
      chk("R6 busy reply byte", tx_byte, {4'hA, 4'd1});
      chk("R9 no overrun yet", overrun, 0);
      send(8'd3);
      chk("R9 kept byte", tx_byte, {4'hA, 4'd1});
      chk("R9 overrun set", overrun, 1);
      repeat (3) @(negedge clk);
      chk("R8 held valid", tx_valid, 1);
      chk("R8 held byte", tx_byte, {4'hA, 4'd1});
      tx_busy = 1'b0;
      send(8'd4);
      chk("R10 loaded", tx_valid, 1);
      chk("R10 byte", tx_byte, {4'hA, 4'd3});
      @(negedge clk);
      chk("R8 released", tx_valid, 0);
      chk("R9 sticky", overrun, 1);
      do_reset();
      chk("R1 overrun cleared", overrun, 0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_single_burst();
      t_non_null();
      t_restart();
      t_addresses();
      t_busy();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule